// File: doc/BRIEF.md
# Variable-Pulse-Width Symbol Transmitter

This block produces the timed line levels of a variable-pulse-width serial bus. Each symbol is either a data bit, a frame start, an end-of-data mark, an end-of-frame mark or an inter-frame gap. A requester offers one symbol code at a time over a valid/ready handshake. The block then holds the bus line at an active or passive level for a set number of bus ticks and raises `done` on the last tick. The time base comes from an external single-cycle `tick` strobe.

The level of a data bit depends on its position in the frame. The first bit after a frame start is passive, and later bits alternate. The pulse width depends on both the bit value and the level. A mode input selects one of two duration tables: one for an integer-ratio bus clock and one for a binary-ratio bus clock. The mode is captured when a request is accepted. A higher layer holds the next request ready, so that symbols follow one another with no idle cycle between them.

Top module: `vpw_tx`

## Requirements
- R1: After reset, `busOut`, `busy` and `done` are 0 and `reqReady` is 1.
- R2: `reqReady` is 1 exactly when the block is idle or is in its `done` cycle. A request with a legal code is accepted when `reqValid` and `reqReady` are both 1, and `busy` is 1 from the next cycle.
- R3: Symbol codes are 0 = data zero, 1 = data one, 2 = frame start, 3 = end of data, 4 = end of frame, 5 = inter-frame gap. Frame start drives `busOut` = 1 (active). Codes 3, 4 and 5 drive `busOut` = 0 (passive). While idle, `busOut` is 0.
- R4: The first data bit after a frame start is passive, and each later data bit takes the opposite level from the previous one. Any non-data symbol restarts this sequence.
- R5: A data bit is short when it is passive with value 0 or active with value 1. In the other two cases it is long.
- R6: With `binMode` = 0, the pulse lengths in ticks are: short 64, long 128, frame start 200, end of data 164, end of frame 240, gap 300.
- R7: With `binMode` = 1, the pulse lengths in ticks are: short 67, long 134, frame start 210, end of data 172, end of frame 252, gap 315.
- R8: A symbol lasts for the stated number of `tick` pulses counted after the accept cycle. `done` is a one-cycle pulse in the cycle of the last counted tick. `busOut` holds steady until then, and `busy` falls in the next cycle unless a new request is accepted.
- R9: A request accepted in a `done` cycle takes effect at the next clock edge, so `busy` stays 1 with no gap.
- R10: Codes 6 and 7 are never accepted. They leave `busy`, `busOut` and the level sequence unchanged.
- R11: `binMode` is sampled only at acceptance. A change while a symbol is running does not alter that symbol's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle bus time-base strobe |
| reqValid | input | 1 | Symbol request present |
| reqSym | input | 3 | Symbol code |
| binMode | input | 1 | 1 selects the binary-clock durations |
| reqReady | output | 1 | Request may be accepted this cycle |
| busy | output | 1 | A symbol is being driven |
| done | output | 1 | Last tick of the current symbol |
| busOut | output | 1 | Bus level, 1 = active |

## Verification
The assertions check the following on every cycle:
- the handshake: ready is low while a symbol runs, and `busy` falls only after `done`;
- that `done` lasts a single cycle;
- that the line level is stable inside a symbol;
- the level of the non-data symbols;
- that illegal codes are refused;
- that `busy` continues across a back-to-back hand-off.

The exact tick counts of both tables, the alternation of data-bit levels across a frame and its restart at the next frame start, and the ignored mid-symbol mode changes can only be shown by the scoreboard scenarios. Those scenarios compare each completed symbol with a model of the frame.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  localparam int DUR_W = 9;
  localparam int LAST_CODE = 5;

  typedef enum logic [2:0] {
    SYM_ZERO = 3'd0,
    SYM_ONE  = 3'd1,
    SYM_SOF  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_EOF  = 3'd4,
    SYM_GAP  = 3'd5
  } symCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     decr;
    symCode_e sym;
    logic     lvl;
    logic     binClk;
  } ctrlStrobe_t;
endpackage

// File: rtl/vpw_dp.sv
module vpw_dp
  import vpw_pkg::*;
#(
  parameter int CNT_W     = DUR_W,
  parameter int INT_SHORT = 64,
  parameter int INT_LONG  = 128,
  parameter int INT_SOF   = 200,
  parameter int INT_EOD   = 164,
  parameter int INT_EOF   = 240,
  parameter int INT_GAP   = 300,
  parameter int BIN_SHORT = 67,
  parameter int BIN_LONG  = 134,
  parameter int BIN_SOF   = 210,
  parameter int BIN_EOD   = 172,
  parameter int BIN_EOF   = 252,
  parameter int BIN_GAP   = 315
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  output logic        cntOne
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durSel;
  logic             isShort;
  int               durInt;

  always_comb begin
    // passive zero and active one are short
    isShort = (strb.sym == SYM_ZERO) ? !strb.lvl : strb.lvl;
    case (strb.sym)
      SYM_ZERO, SYM_ONE:
        durInt = isShort ? (strb.binClk ? BIN_SHORT : INT_SHORT)
                         : (strb.binClk ? BIN_LONG  : INT_LONG);
      SYM_SOF: durInt = strb.binClk ? BIN_SOF : INT_SOF;
      SYM_EOD: durInt = strb.binClk ? BIN_EOD : INT_EOD;
      SYM_EOF: durInt = strb.binClk ? BIN_EOF : INT_EOF;
      SYM_GAP: durInt = strb.binClk ? BIN_GAP : INT_GAP;
      default: durInt = 1;
    endcase
    durSel = CNT_W'(durInt);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strb.load)   cnt <= durSel;
    else if (strb.decr)   cnt <= cnt - 1'b1;
  end

  assign cntOne = (cnt == CNT_W'(1));
endmodule

// File: rtl/vpw_ctrl.sv
module vpw_ctrl
  import vpw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        reqValid,
  input  logic [2:0]  reqSym,
  input  logic        binMode,
  input  logic        cntOne,
  output logic        reqReady,
  output logic        busy,
  output logic        done,
  output logic        busOut,
  output ctrlStrobe_t strb
);
  logic     busyQ;
  logic     levelQ;
  logic     nextAct;
  logic     legal;
  logic     accept;
  logic     reqLvl;
  logic     isData;
  symCode_e sym;

  always_comb begin
    sym      = symCode_e'(reqSym);
    legal    = (reqSym <= 3'(LAST_CODE));
    isData   = (sym == SYM_ZERO) || (sym == SYM_ONE);
    done     = busyQ && tick && cntOne;
    reqReady = !busyQ || done;
    accept   = reqValid && reqReady && legal;
    if (sym == SYM_SOF) reqLvl = 1'b1;
    else if (isData)    reqLvl = nextAct;
    else                reqLvl = 1'b0;
    strb.load   = accept;
    strb.decr   = busyQ && tick && !done;
    strb.sym    = sym;
    strb.lvl    = reqLvl;
    strb.binClk = binMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      levelQ  <= 1'b0;
      nextAct <= 1'b0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      levelQ  <= reqLvl;
      nextAct <= isData ? !nextAct : 1'b0;
    end else if (done) begin
      busyQ   <= 1'b0;
      levelQ  <= 1'b0;
    end
  end

  assign busy   = busyQ;
  assign busOut = levelQ;
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_pkg::*;
#(
  parameter int CNT_W = DUR_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       reqValid,
  input  logic [2:0] reqSym,
  input  logic       binMode,
  output logic       reqReady,
  output logic       busy,
  output logic       done,
  output logic       busOut
);
  ctrlStrobe_t strb;
  logic        cntOne;

  vpw_ctrl ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .reqValid(reqValid),
    .reqSym(reqSym), .binMode(binMode), .cntOne(cntOne),
    .reqReady(reqReady), .busy(busy), .done(done), .busOut(busOut),
    .strb(strb)
  );

  vpw_dp #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntOne(cntOne)
  );
endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       reqValid,
  input logic [2:0] reqSym,
  input logic       binMode,
  input logic       reqReady,
  input logic       busy,
  input logic       done,
  input logic       busOut
);
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> !reqReady);

  assert_sof_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSym == 3'd2) |=> (busy && busOut));

  assert_passive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqSym == 3'd3 || reqSym == 3'd4 || reqSym == 3'd5))
      |=> (busy && !busOut));

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busOut);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(busOut));

  assert_handoff_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && reqValid && reqSym <= 3'd5) |=> busy);

  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqSym > 3'd5) |=> !busy);
endmodule

bind vpw_tx vpw_tx_chk chk (
  .clk(clk), .rstN(rstN), .tick(tick), .reqValid(reqValid), .reqSym(reqSym),
  .binMode(binMode), .reqReady(reqReady), .busy(busy), .done(done),
  .busOut(busOut)
);

// File: tb/vpw_tx_test.sv
`timescale 1ns/1ps
module vpw_tx_test;
  logic       clk = 0, rstN = 0, tick = 0, reqValid = 0, binMode = 0;
  logic [2:0] reqSym = 0;
  logic       reqReady, busy, done, busOut;

  typedef struct {
    int    lvl;
    int    dur;
    string tagD;
    string tagL;
    bit    b2b;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   total = 0, bad = 0;
  bit   modelAct = 0;
  bit   recOn = 0, lvlBad = 0, prevDoneNoAcc = 0;
  int   tickCnt = 0;

  vpw_tx uut (.clk(clk), .rstN(rstN), .tick(tick), .reqValid(reqValid),
              .reqSym(reqSym), .binMode(binMode), .reqReady(reqReady),
              .busy(busy), .done(done), .busOut(busOut));

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int expDur(int code, int lvl, bit bm);
    bit shortP;
    case (code)
      0, 1: begin
        shortP = (code == 0) ? (lvl == 0) : (lvl == 1);
        return shortP ? (bm ? 67 : 64) : (bm ? 134 : 128);
      end
      2: return bm ? 210 : 200;
      3: return bm ? 172 : 164;
      4: return bm ? 252 : 240;
      default: return bm ? 315 : 300;
    endcase
  endfunction

  // tick every third cycle, driven just after the rising edge
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      tick = (div == 2);
      div = (div + 1) % 3;
    end
  end

  // driver: push expectation, hold request until accepted
  task automatic sendSym(int code, bit bm);
    exp_t e;
    int lvl;
    @(posedge clk); #1;
    if (code == 2) begin lvl = 1; modelAct = 0; end
    else if (code <= 1) begin lvl = modelAct; modelAct = !modelAct; end
    else begin lvl = 0; modelAct = 0; end
    e.lvl  = lvl;
    e.dur  = expDur(code, lvl, bm);
    e.tagD = (code <= 1) ? (bm ? "R5 R7 data width" : "R5 R6 data width")
                         : (bm ? "R7 R8 symbol width" : "R6 R8 symbol width");
    e.tagL = (code <= 1) ? "R4 data level" : "R3 symbol level";
    e.b2b  = busy;
    expQ.push_back(e);
    reqValid = 1; reqSym = 3'(code); binMode = bm;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    binMode = !bm;   // R11: change mode mid-symbol
  endtask

  task automatic sendFrame(logic [7:0] b0, logic [7:0] b1, bit bm);
    sendSym(2, bm);
    for (int i = 7; i >= 0; i--) sendSym(int'(b0[i]), bm);
    for (int i = 7; i >= 0; i--) sendSym(int'(b1[i]), bm);
    sendSym(3, bm);
    sendSym(4, bm);
    sendSym(5, bm);
    reqValid = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  // monitor / scoreboard
  initial begin
    bit acc;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (recOn && tick) begin
          tickCnt++;
          if (busOut !== cur.lvl[0]) lvlBad = 1;
        end
        if (prevDoneNoAcc) check(!busy, "R8 busy after done", int'(busy), 0);
        if (busy && !done && reqReady)
          check(0, "R2 ready while busy", 1, 0);
        if (done) begin
          if (!recOn) check(0, "R8 done without symbol", 1, 0);
          else begin
            check(tickCnt == cur.dur, cur.tagD, tickCnt, cur.dur);
            check(!lvlBad, cur.tagL, int'(!busOut), cur.lvl);
            recOn = 0;
          end
        end
        acc = reqValid && reqReady && (reqSym <= 3'd5);
        if (acc) begin
          if (expQ.size() == 0) check(0, "R10 unexpected accept", 1, 0);
          else begin
            cur = expQ.pop_front();
            if (cur.b2b) check(done, "R9 back-to-back handoff", int'(done), 1);
            recOn = 1; tickCnt = 0; lvlBad = 0;
          end
        end
        prevDoneNoAcc = done && !acc;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(!busOut && !busy && !done && reqReady, "R1 reset state",
          {busOut, busy, done, reqReady}, 1);
    // R10: illegal codes while idle
    @(posedge clk); #1 reqValid = 1; reqSym = 3'd6;
    repeat (5) @(posedge clk);
    #1 reqSym = 3'd7;
    repeat (5) @(posedge clk);
    #1 reqValid = 0;
    @(negedge clk);
    check(!busy && !busOut && reqReady, "R10 illegal code ignored",
          {busy, busOut, reqReady}, 1);
    // integer-clock frames
    sendFrame(8'hA5, 8'h3C, 0);
    waitIdle();
    // binary-clock frames
    sendFrame(8'h0F, 8'hB2, 1);
    waitIdle();
    // R4: short frame, then new frame start restarts level sequence
    sendSym(2, 0); sendSym(1, 0); sendSym(1, 0); sendSym(0, 0); sendSym(3, 1);
    reqValid = 0;
    waitIdle();
    // R10: illegal code between frames leaves sequence state alone
    @(posedge clk); #1 reqValid = 1; reqSym = 3'd7;
    repeat (4) @(posedge clk);
    #1 reqValid = 0;
    @(negedge clk);
    check(!busy && !busOut, "R10 illegal code between frames", {busy, busOut}, 0);
    sendSym(2, 1); sendSym(0, 1); sendSym(1, 1); sendSym(5, 0);
    reqValid = 0;
    waitIdle();
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !recOn, "R8 all symbols completed", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule